// File: doc/BRIEF.md
# Vectored Priority Interrupt Encoder

This block lets an 8-bit microprocessor tell several interrupt sources apart through a single I/O location. Eight active-low request lines enter the block. The block keeps the eligible requests, picks the one with the highest number and drives one combined active-low interrupt line to the CPU. When that line goes active, the block stores the winning source number in a register. The number sits one bit position up, so a read of the port returns twice the source number. The handler uses that byte directly as an offset into a table of 2-byte handler addresses, one entry per source in source-number order.

A CPU write to the same location loads a priority threshold. While a handler runs, software writes the accepted level. That level and every lower level are then held off, and only higher levels can interrupt. The block decodes its own read and write strobes from an address comparator, a bus-cycle enable and the CPU read/write signal. It drives read data together with an output-enable, in the style of a tri-state bus.

Top module: `vec_irq_encoder`

## Requirements
- R1: A port read returns the latched source number on data bits 3:1. Bit 0 and bits 7:4 read as zero, so the byte equals twice the source number.
- R2: `rd_stb_n` is low only when `bus_en` is 1, `bus_addr` equals `PORT_ADDR` and `bus_rw` is 1 (read). It stays high on writes and on any other address.
- R3: `wr_stb_n` is low only when `bus_en` is 1, `bus_addr` equals `PORT_ADDR` and `bus_rw` is 0 (write).
- R4: Among eligible requests, the highest number wins: request 7 has the top priority and request 0 the lowest.
- R5: The threshold register is 4 bits wide and resets to 0xF. At a clock edge with `wr_stb_n` low it loads `wr_data[3:0]`, and bits 7:4 are ignored. A request is eligible when its line is low and either the threshold is 0xF or the request number is strictly greater than the threshold. Threshold values 8 to 14 therefore mask every request.
- R6: `cpu_irq_n` goes low one clock edge after an eligible request appears. It returns high one clock edge after the last eligible request goes away.
- R7: The index register loads the winner at the clock edge where `cpu_irq_n` first goes low. While `rd_stb_n` is low, the index is held and `cpu_irq_n` does not newly assert. The pending assertion and its capture happen at the first edge after the strobe ends.
- R8: `rd_oe` is 1 only while `rd_stb_n` is low. When `rd_oe` is 0, `rd_data` is 0x00.
- R9: With no eligible request, a read returns the value from the last capture. After reset that value is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_n | input | 8 | Active-low interrupt requests, bit n is source n |
| bus_addr | input | 16 | CPU address bus |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_en | input | 1 | Bus cycle valid |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Read data, 0x00 when not enabled |
| rd_oe | output | 1 | Read data output enable |
| rd_stb_n | output | 1 | Decoded active-low read strobe |
| wr_stb_n | output | 1 | Decoded active-low write strobe |
| cpu_irq_n | output | 1 | Combined active-low interrupt to the CPU |

## Verification
Two events can fall in the same cycle: the combined interrupt wanting to assert and an index capture, and a CPU read of the port that must see a stable index. The bench holds a read strobe active while it applies a new eligible request. It then checks three things: the interrupt line stays inactive, the read byte keeps the old index, and the first edge after the strobe is released both asserts the interrupt and captures the new winner. The sweep covers all 256 request patterns under ten thresholds and checks the expected byte, which is computed arithmetically.

// File: rtl/vie_pkg.sv
package vie_pkg;
   // Threshold code that enables every level
   localparam int unsigned THR_W      = 4;
   localparam logic [THR_W-1:0] THR_OPEN = '1;
endpackage

// File: rtl/vie_addr_decode.sv
module vie_addr_decode #(
   parameter int unsigned ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hFE00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rw,
   input  logic              bus_en,
   output logic              rd_stb_n,
   output logic              wr_stb_n
);
   logic hit;

   assign hit      = bus_en && (bus_addr == PORT_ADDR);
   assign rd_stb_n = !(hit && bus_rw);
   assign wr_stb_n = !(hit && !bus_rw);

   // R2
   rd_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb_n |-> (bus_rw && bus_en && bus_addr == PORT_ADDR));
   // R3
   wr_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb_n |-> (!bus_rw && bus_en && bus_addr == PORT_ADDR));
endmodule

// File: rtl/vie_prio_pick.sv
module vie_prio_pick
   import vie_pkg::*;
#(
   parameter int unsigned N_SRC = 8,
   localparam int unsigned IDX_W = $clog2(N_SRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  req_n,
   input  logic              wr_stb_n,
   input  logic [THR_W-1:0]  wr_nib,
   output logic              any_elig,
   output logic [IDX_W-1:0]  win_idx
);
   logic [THR_W-1:0] thr_q;
   logic [N_SRC-1:0] elig;
   logic [N_SRC-1:0] win_oh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         thr_q <= THR_OPEN;
      else if (!wr_stb_n) thr_q <= wr_nib;
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_elig
      localparam logic [THR_W-1:0] LVL = THR_W'(i);
      assign elig[i] = !req_n[i] && ((thr_q == THR_OPEN) || (LVL > thr_q));
   end

   always_comb begin
      win_idx = '0;
      win_oh  = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (elig[i]) begin
            win_idx = IDX_W'(i);
            win_oh  = N_SRC'(1) << i;
         end
      end
   end

   assign any_elig = |elig;

   // R4
   one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win_oh) && (any_elig == (win_oh != '0)));
   // R5
   thr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb_n |=> thr_q == $past(wr_nib));
endmodule

// File: rtl/vie_index_latch.sv
module vie_index_latch #(
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any_elig,
   input  logic [IDX_W-1:0] win_idx,
   input  logic             rd_stb_n,
   output logic             irq_q,
   output logic [IDX_W-1:0] idx_q
);
   logic rise_ok;

   assign rise_ok = any_elig && !irq_q && rd_stb_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         idx_q <= '0;
      end else begin
         if (irq_q) irq_q <= any_elig;
         else       irq_q <= rise_ok;
         if (rise_ok) idx_q <= win_idx;
      end
   end

   // R7
   idx_hold_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb_n |=> $stable(idx_q));
   // R7
   no_rise_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stb_n && !irq_q) |=> !irq_q);
   // R6
   irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !any_elig |=> !irq_q);
endmodule

// File: rtl/vec_irq_encoder.sv
module vec_irq_encoder
   import vie_pkg::*;
#(
   parameter int unsigned N_SRC  = 8,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hFE00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_req_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rw,
   input  logic              bus_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_oe,
   output logic              rd_stb_n,
   output logic              wr_stb_n,
   output logic              cpu_irq_n
);
   localparam int unsigned IDX_W = $clog2(N_SRC);

   if (N_SRC < 2 || (1 << IDX_W) != N_SRC) begin : g_bad_src
      $error("N_SRC must be a power of two of at least 2");
   end
   if (IDX_W + 1 > DATA_W || IDX_W >= THR_W) begin : g_bad_width
      $error("index does not fit data byte or threshold range");
   end

   logic             any_elig;
   logic [IDX_W-1:0] win_idx;
   logic [IDX_W-1:0] idx_q;
   logic             irq_q;

   vie_addr_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rw(bus_rw),
      .bus_en(bus_en), .rd_stb_n(rd_stb_n), .wr_stb_n(wr_stb_n)
   );

   vie_prio_pick #(.N_SRC(N_SRC)) u_pick (
      .clk(clk), .rst_n(rst_n), .req_n(irq_req_n), .wr_stb_n(wr_stb_n),
      .wr_nib(wr_data[THR_W-1:0]), .any_elig(any_elig), .win_idx(win_idx)
   );

   vie_index_latch #(.IDX_W(IDX_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .any_elig(any_elig), .win_idx(win_idx),
      .rd_stb_n(rd_stb_n), .irq_q(irq_q), .idx_q(idx_q)
   );

   assign cpu_irq_n = !irq_q;
   assign rd_oe     = !rd_stb_n;
   assign rd_data   = rd_oe ? DATA_W'({idx_q, 1'b0}) : '0;

   // R1
   read_byte_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_oe |-> (rd_data[0] == 1'b0 && (rd_data >> (IDX_W + 1)) == '0));
   // R8
   quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_oe |-> rd_data == '0);
   // R6
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_elig && rd_stb_n) |=> !cpu_irq_n);
endmodule

// File: tb/vec_irq_encoder_tb.sv
module vec_irq_encoder_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] PORT = 16'hFE00;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_req_n = 8'hFF;
   logic [15:0] bus_addr = 16'h0000;
   logic       bus_rw = 1'b1;
   logic       bus_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       rd_oe, rd_stb_n, wr_stb_n, cpu_irq_n;

   int checks = 0;
   int failures = 0;
   int last_idx = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_irq_encoder u_dut (
      .clk(clk), .rst_n(rst_n), .irq_req_n(irq_req_n), .bus_addr(bus_addr),
      .bus_rw(bus_rw), .bus_en(bus_en), .wr_data(wr_data), .rd_data(rd_data),
      .rd_oe(rd_oe), .rd_stb_n(rd_stb_n), .wr_stb_n(wr_stb_n),
      .cpu_irq_n(cpu_irq_n)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic idle_bus();
      @(negedge clk);
      bus_en = 1'b0; bus_rw = 1'b1; bus_addr = 16'h0000;
   endtask

   task automatic write_port(input logic [7:0] v);
      @(negedge clk);
      bus_en = 1'b1; bus_rw = 1'b0; bus_addr = PORT; wr_data = v;
      #1;
      chk("R3 wr strobe", wr_stb_n, 0);
      chk("R2 no rd strobe on write", rd_stb_n, 1);
      chk("R8 no oe on write", rd_oe, 0);
      idle_bus();
   endtask

   task automatic read_port(input string req, input int exp);
      @(negedge clk);
      bus_en = 1'b1; bus_rw = 1'b1; bus_addr = PORT;
      #1;
      chk("R2 rd strobe", rd_stb_n, 0);
      chk("R8 oe on read", rd_oe, 1);
      chk(req, rd_data, exp);
      idle_bus();
   endtask

   function automatic int expect_win(input logic [7:0] req_n, input int thr);
      int w = -1;
      for (int i = 0; i < 8; i++)
         if (!req_n[i] && (thr == 15 || i > thr)) w = i;
      return w;
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int thr_list[10] = '{15, 0, 1, 2, 3, 4, 5, 6, 7, 9};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // reset state
      chk("R6 irq idle after reset", cpu_irq_n, 1);
      chk("R8 oe idle after reset", rd_oe, 0);
      chk("R8 data zero when idle", rd_data, 0);
      read_port("R9 reset read 0x00", 0);

      // R5 reset threshold open: request 0 alone is eligible
      @(negedge clk); irq_req_n = 8'hFE;
      @(negedge clk); @(negedge clk);
      chk("R5 reset thr open irq", cpu_irq_n, 0);
      read_port("R5 reset thr index 0", 0);
      @(negedge clk); irq_req_n = 8'hFF;
      @(negedge clk);
      chk("R6 irq drop one edge", cpu_irq_n, 1);

      // R2/R3 wrong address or no bus cycle
      @(negedge clk);
      bus_en = 1'b1; bus_rw = 1'b1; bus_addr = PORT ^ 16'h0001; #1;
      chk("R2 other addr no rd", rd_stb_n, 1);
      chk("R8 other addr data", rd_data, 0);
      bus_rw = 1'b0; #1;
      chk("R3 other addr no wr", wr_stb_n, 1);
      bus_addr = PORT; bus_en = 1'b0; #1;
      chk("R3 no bus cycle no wr", wr_stb_n, 1);
      chk("R2 no bus cycle no rd", rd_stb_n, 1);
      idle_bus();

      // full sweep of patterns and thresholds
      foreach (thr_list[t]) begin
         write_port(8'hA0 | 8'(thr_list[t]));  // R5 upper nibble ignored
         for (int p = 0; p < 256; p++) begin
            int w;
            @(negedge clk); irq_req_n = 8'hFF;
            @(negedge clk);
            irq_req_n = 8'(p);
            w = expect_win(8'(p), thr_list[t]);
            @(negedge clk);
            chk("R6 irq after one edge", cpu_irq_n, (w >= 0) ? 0 : 1);
            if (w >= 0) last_idx = w;
            read_port((w >= 0) ? "R4 R1 winner byte" : "R9 held byte",
                      last_idx * 2);
         end
      end

      // R7: read strobe active while a new eligible request arrives
      write_port(8'h0F);
      @(negedge clk); irq_req_n = 8'hFF;
      @(negedge clk);
      irq_req_n = 8'hFB;  // source 2
      bus_en = 1'b1; bus_rw = 1'b1; bus_addr = PORT;
      @(negedge clk); #1;
      chk("R7 no irq rise in read", cpu_irq_n, 1);
      chk("R7 index held in read", rd_data, last_idx * 2);
      @(negedge clk); #1;
      chk("R7 still held", rd_data, last_idx * 2);
      bus_en = 1'b0;
      @(negedge clk); #1;
      chk("R7 irq rises after read", cpu_irq_n, 0);
      last_idx = 2;
      read_port("R7 captured after read", 4);

      // R5 threshold equal level masked, higher level passes
      write_port(8'h05);
      @(negedge clk); irq_req_n = 8'hFF;
      @(negedge clk); irq_req_n = 8'hDF;  // source 5
      @(negedge clk);
      chk("R5 level equal thr masked", cpu_irq_n, 1);
      irq_req_n = 8'h9F;  // sources 5 and 6
      @(negedge clk);
      chk("R5 level above thr passes", cpu_irq_n, 0);
      read_port("R1 source 6 byte", 12);
      irq_req_n = 8'hFF;
      @(negedge clk);
      chk("R6 drop after removal", cpu_irq_n, 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule